// File: doc/BRIEF.md
# Gated Edge-Count Frequency Meter

This block measures the frequency of an external intermediate-frequency signal by counting its rising edges for a precisely timed window. The window length comes from whole periods of a 75 kHz timebase, which reaches the block as a one-cycle strobe in the system clock domain. Software first writes a small configuration (measurement mode, window length, pin role), then pulses a start command. When the window closes, a completion flag rises and a 20-bit edge count can be read. Reading the result or starting again clears the flag.

The edges are counted in their own fast sampling clock domain. The input signal, the window level and the enable qualifiers are synchronised into that domain. When the window has closed, a toggle returns to the system domain. The system domain then captures the count, which no longer changes at that point. The same pin can also serve as a plain digital input. It comes out of reset in counting mode. A block input marks low-power and halted states, and while it is high no edges are counted.

Top module: `freq_gate_meter`

## Requirements
- R1: After reset, done, busy, result and pin_level are all 0, and the pin is in counting mode (cfg_port = 0).
- R2: With mode code 00, an accepted start clears the count, and every rising edge of sig_in inside the window adds one. The value is captured into result when the window closes.
- R3: Window code 00, 01, 10 or 11 selects 75, 300, 600 or 2400 timebase strobes, counted from the strobes that follow the accepted start. done rises no sooner than that many strobe periods minus one period after start, and at most 20 system cycles later than that.
- R4: Mode codes 01, 10 and 11 are reserved. A start under them is ignored: busy and done stay 0.
- R5: busy is high from an accepted start until the result is captured. done rises in the cycle busy falls.
- R6: A one-cycle rd_en pulse clears done and leaves result unchanged.
- R7: An accepted start clears done and sets result to 0 on the next clock. result otherwise holds until the next capture.
- R8: The count saturates at all ones (2^CNT_W - 1) and never wraps.
- R9: While in_block is high, no edges are counted.
- R10: With cfg_port = 1, pin_level follows sig_in through a two-stage synchroniser and no edges are counted. With cfg_port = 0, pin_level reads 0.
- R11: A start while busy is high is ignored. The window keeps its original start time and the count keeps accumulating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| cclk | input | 1 | Fast sampling clock for the edge counter |
| tick | input | 1 | One-cycle 75 kHz timebase strobe, clk domain |
| sig_in | input | 1 | Measured signal / plain digital input |
| in_block | input | 1 | High during halt, backup or hold-off: input disabled |
| cfg_we | input | 1 | Write strobe for the configuration fields |
| cfg_mode | input | 2 | Measurement mode; 00 = frequency, others reserved |
| cfg_gate | input | 2 | Window length code (00..11 = 75/300/600/2400 strobes) |
| cfg_port | input | 1 | 1 = plain input role, 0 = counting role |
| start | input | 1 | Start command pulse |
| rd_en | input | 1 | Result read pulse, clears done |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | Completion flag |
| result | output | CNT_W | Captured edge count |
| pin_level | output | 1 | Synchronised pin value in plain input role |

## Verification
A window counter that has gone wrong shows directly at the ports, within one measurement: done rises too early or too late against the strobe count. Because the count saturates, a lost clear at start shows as a count that carries over from the previous run. A stuck qualifier or a broken synchroniser on the enable path appears as a nonzero result where zero is expected, or as a zero result after a burst. A wrong capture toggle leaves busy high and done low. Each of these shows up at the ports by the end of the affected window plus a few synchroniser cycles.

// File: rtl/fcnt_pkg.sv
package fcnt_pkg;
   typedef enum logic [1:0] {
      MODE_FREQ = 2'b00,
      MODE_RSV1 = 2'b01,
      MODE_RSV2 = 2'b10,
      MODE_RSV3 = 2'b11
   } fc_mode_e;

   // window length in timebase strobes for a gate code
   function automatic int unsigned gate_ticks(input logic [1:0] code, input int unsigned base);
      case (code)
         2'b00:   return base;
         2'b01:   return base * 4;
         2'b10:   return base * 8;
         default: return base * 32;
      endcase
   endfunction
endpackage

// File: rtl/fcnt_sync.sv
module fcnt_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial begin
      a_stages: assert (STAGES >= 2 && W >= 1) else $error("fcnt_sync: bad parameters");
   end

   logic [W-1:0] st [STAGES];

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) st[0] <= '0;
               else        st[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) st[gi] <= '0;
               else        st[gi] <= st[gi-1];
         end
      end
   endgenerate

   assign q = st[STAGES-1];
endmodule

// File: rtl/fcnt_gate_timer.sv
module fcnt_gate_timer
   import fcnt_pkg::*;
#(
   parameter int BASE_TICKS = 75
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       start_ok,
   input  logic [1:0] gate_code,
   output logic       gate_open
);
   localparam int TW = $clog2(BASE_TICKS * 32 + 1);

   initial begin
      a_base: assert (BASE_TICKS >= 2) else $error("fcnt_gate_timer: BASE_TICKS too small");
   end

   logic [1:0]    code_q;
   logic [TW-1:0] tcnt;
   logic [TW-1:0] last_idx;

   assign last_idx = TW'(gate_ticks(code_q, BASE_TICKS) - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_open <= 1'b0;
         tcnt      <= '0;
         code_q    <= 2'b00;
      end else if (start_ok) begin
         gate_open <= 1'b1;
         tcnt      <= '0;
         code_q    <= gate_code;
      end else if (gate_open && tick) begin
         if (tcnt == last_idx) gate_open <= 1'b0;
         else                  tcnt      <= tcnt + 1'b1;
      end
   end

   // checker: independent count of strobes seen while open
   logic [TW-1:0] seen;
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                 seen <= '0;
      else if (start_ok)          seen <= '0;
      else if (gate_open && tick) seen <= seen + 1'b1;

   p_gate_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gate_open) |-> seen == TW'(gate_ticks(code_q, BASE_TICKS)));
endmodule

// File: rtl/fcnt_edge_counter.sv
module fcnt_edge_counter #(
   parameter int CNT_W  = 20,
   parameter int STAGES = 2
) (
   input  logic             cclk,
   input  logic             rst_n,
   input  logic             sig_in,
   input  logic             gate_in,
   input  logic             en_in,
   output logic [CNT_W-1:0] cnt_val,
   output logic             close_tgl
);
   localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

   logic [2:0] raw, syn;
   logic       g_d, s_d;

   assign raw = {gate_in, sig_in, en_in};

   fcnt_sync #(.W(3), .STAGES(STAGES)) u_sync (
      .clk(cclk), .rst_n(rst_n), .d(raw), .q(syn));

   logic g_s, s_s, e_s;
   assign {g_s, s_s, e_s} = syn;

   always_ff @(posedge cclk or negedge rst_n) begin
      if (!rst_n) begin
         g_d       <= 1'b0;
         s_d       <= 1'b0;
         cnt_val   <= '0;
         close_tgl <= 1'b0;
      end else begin
         g_d <= g_s;
         s_d <= s_s;
         if (g_s && !g_d)
            cnt_val <= '0;
         else if (g_s && e_s && s_s && !s_d && cnt_val != ALL_ONES)
            cnt_val <= cnt_val + 1'b1;
         if (g_d && !g_s)
            close_tgl <= ~close_tgl;
      end
   end

   p_no_wrap_r8: assert property (@(posedge cclk) disable iff (!rst_n)
      $past(g_s && g_d) |-> cnt_val >= $past(cnt_val));

   p_blocked_r9: assert property (@(posedge cclk) disable iff (!rst_n)
      $past(!e_s && g_d) |-> $stable(cnt_val));
endmodule

// File: rtl/freq_gate_meter.sv
module freq_gate_meter
   import fcnt_pkg::*;
#(
   parameter int CNT_W      = 20,
   parameter int BASE_TICKS = 75,
   parameter int STAGES     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cclk,
   input  logic             tick,
   input  logic             sig_in,
   input  logic             in_block,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_mode,
   input  logic [1:0]       cfg_gate,
   input  logic             cfg_port,
   input  logic             start,
   input  logic             rd_en,
   output logic             busy,
   output logic             done,
   output logic [CNT_W-1:0] result,
   output logic             pin_level
);
   initial begin
      a_width: assert (CNT_W >= 2 && CNT_W <= 32) else $error("freq_gate_meter: CNT_W out of range");
   end

   fc_mode_e   mode_q;
   logic [1:0] gate_q;
   logic       port_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         mode_q <= MODE_FREQ;
         gate_q <= 2'b00;
         port_q <= 1'b0;
      end else if (cfg_we) begin
         mode_q <= fc_mode_e'(cfg_mode);
         gate_q <= cfg_gate;
         port_q <= cfg_port;
      end

   logic start_ok;
   assign start_ok = start && !busy && (mode_q == MODE_FREQ);

   logic gate_open;
   fcnt_gate_timer #(.BASE_TICKS(BASE_TICKS)) u_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start_ok(start_ok),
      .gate_code(gate_q), .gate_open(gate_open));

   logic [CNT_W-1:0] cnt_val;
   logic             close_tgl;
   fcnt_edge_counter #(.CNT_W(CNT_W), .STAGES(STAGES)) u_count (
      .cclk(cclk), .rst_n(rst_n), .sig_in(sig_in), .gate_in(gate_open),
      .en_in(~port_q & ~in_block), .cnt_val(cnt_val), .close_tgl(close_tgl));

   // window-closed toggle back into clk domain
   logic t_s, t_d, cap;
   fcnt_sync #(.W(1), .STAGES(STAGES)) u_tsync (
      .clk(clk), .rst_n(rst_n), .d(close_tgl), .q(t_s));

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) t_d <= 1'b0;
      else        t_d <= t_s;
   assign cap = t_s ^ t_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         done   <= 1'b0;
         result <= '0;
      end else if (start_ok) begin
         busy   <= 1'b1;
         done   <= 1'b0;
         result <= '0;
      end else if (cap) begin
         busy   <= 1'b0;
         done   <= 1'b1;
         result <= cnt_val;
      end else if (rd_en) begin
         done   <= 1'b0;
      end
   end

   logic p_s;
   fcnt_sync #(.W(1), .STAGES(STAGES)) u_psync (
      .clk(clk), .rst_n(rst_n), .d(sig_in), .q(p_s));
   assign pin_level = port_q & p_s;

   p_rd_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !cap && !start_ok) |=> !done && $stable(result));

   p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap && !start_ok) |=> $stable(result));

   p_reserved_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && mode_q != MODE_FREQ) |=> !busy);

   p_done_with_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $fell(busy));

   p_busy_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !cap) |=> busy && $stable(result));
endmodule

// File: tb/freq_gate_meter_tb_top.sv
`timescale 1ns/1ps
module freq_gate_meter_tb_top;
   logic clk = 1'b0, cclk = 1'b0, rst_n = 1'b0, tick = 1'b0;
   logic sig_in = 1'b0, in_block = 1'b0, cfg_we = 1'b0, cfg_port = 1'b0;
   logic start = 1'b0, rd_en = 1'b0;
   logic [1:0] cfg_mode = 2'b00, cfg_gate = 2'b00;
   logic busy, done, pin_level, s_busy, s_done, s_pin;
   logic [19:0] result;
   logic [5:0]  s_result;

   int errors = 0, checks = 0;

   always #2.5 clk  = ~clk;
   always #2   cclk = ~cclk;

   logic [1:0] div = 2'd0;
   always @(posedge clk) begin
      div  <= div + 2'd1;
      tick <= (div == 2'd3);
   end

   freq_gate_meter dut_i (
      .clk(clk), .rst_n(rst_n), .cclk(cclk), .tick(tick), .sig_in(sig_in),
      .in_block(in_block), .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_gate(cfg_gate),
      .cfg_port(cfg_port), .start(start), .rd_en(rd_en), .busy(busy), .done(done),
      .result(result), .pin_level(pin_level));

   freq_gate_meter #(.CNT_W(6)) sat_i (
      .clk(clk), .rst_n(rst_n), .cclk(cclk), .tick(tick), .sig_in(sig_in),
      .in_block(in_block), .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_gate(cfg_gate),
      .cfg_port(cfg_port), .start(start), .rd_en(rd_en), .busy(s_busy), .done(s_done),
      .result(s_result), .pin_level(s_pin));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int win_len(input logic [1:0] g);
      case (g)
         2'b00: return 75;
         2'b01: return 300;
         2'b10: return 600;
         default: return 2400;
      endcase
   endfunction

   task automatic cfg(input logic [1:0] m, input logic [1:0] g, input logic p);
      @(negedge clk);
      cfg_mode = m; cfg_gate = g; cfg_port = p; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic pulses(input int n);
      for (int k = 0; k < n; k++) begin
         sig_in = 1'b1; #20;
         sig_in = 1'b0; #20;
      end
   endtask

   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   // start, wait margin, emit n edges, wait for done; returns cycles from start
   task automatic run(input int n, input int limit, output int cyc);
      realtime t0;
      @(negedge clk); start = 1'b1; t0 = $realtime;
      @(negedge clk); start = 1'b0;
      repeat (20) @(negedge clk);
      pulses(n);
      while (!done && ($realtime - t0) < limit * 5.0) @(negedge clk);
      cyc = int'(($realtime - t0) / 5.0);
   endtask

   // {mode, gate, edges}
   localparam logic [9:0] VEC [7] = '{
      {2'b00, 2'b00, 6'd12},
      {2'b00, 2'b01, 6'd25},
      {2'b00, 2'b10, 6'd1},
      {2'b00, 2'b11, 6'd28},
      {2'b00, 2'b00, 6'd0},
      {2'b01, 2'b00, 6'd5},
      {2'b11, 2'b10, 6'd3}
   };

   initial begin
      #4000000;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int cyc, len, hold;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(done == 1'b0 && busy == 1'b0, "R1 flags", {busy, done}, 0);
      chk(result == 20'd0, "R1 result", result, 0);
      chk(pin_level == 1'b0, "R1 pin_level", pin_level, 0);

      for (int i = 0; i < 7; i++) begin
         logic [1:0] m, g;
         int n;
         m = VEC[i][9:8]; g = VEC[i][7:6]; n = int'(VEC[i][5:0]);
         len = win_len(g);
         cfg(m, g, 1'b0);
         if (m == 2'b00) begin
            run(n, len * 4 + 400, cyc);
            chk(done == 1'b1, "R5 done set", done, 1);
            chk(busy == 1'b0, "R5 busy clear", busy, 0);
            chk(cyc >= len * 4 - 4 && cyc <= len * 4 + 20, "R3 window", cyc, len * 4);
            chk(result == 20'(n), "R2 count", result, n);
            chk(s_result == 6'(n), "R8 small count", s_result, n);
            hold = result;
            @(negedge clk); rd_en = 1'b1;
            @(negedge clk); rd_en = 1'b0;
            chk(done == 1'b0, "R6 done cleared", done, 0);
            chk(result == 20'(hold), "R6 result held", result, hold);
         end else begin
            run(n, 400, cyc);
            chk(done == 1'b0 && busy == 1'b0, "R4 reserved ignored", {busy, done}, 0);
         end
      end

      // R11 start while busy ignored
      cfg(2'b00, 2'b00, 1'b0);
      begin
         realtime t0;
         @(negedge clk); start = 1'b1; t0 = $realtime;
         @(negedge clk); start = 1'b0;
         repeat (20) @(negedge clk);
         pulses(10);
         pulse_start();
         pulses(5);
         while (!done && ($realtime - t0) < 2000 * 5.0) @(negedge clk);
         cyc = int'(($realtime - t0) / 5.0);
         chk(result == 20'd15, "R11 count kept", result, 15);
         chk(cyc >= 296 && cyc <= 320, "R11 window from first start", cyc, 300);
      end

      // R7 new start clears done and result
      chk(done == 1'b1, "R7 precondition done", done, 1);
      pulse_start();
      chk(done == 1'b0, "R7 done cleared", done, 0);
      chk(result == 20'd0, "R7 result zeroed", result, 0);
      while (!done) @(negedge clk);

      // R9 blocked input
      in_block = 1'b1;
      run(10, 700, cyc);
      chk(result == 20'd0, "R9 blocked count", result, 0);
      in_block = 1'b0;

      // R10 plain input role
      cfg(2'b00, 2'b00, 1'b1);
      sig_in = 1'b1; repeat (3) @(negedge clk);
      chk(pin_level == 1'b1, "R10 pin high", pin_level, 1);
      sig_in = 1'b0; repeat (3) @(negedge clk);
      chk(pin_level == 1'b0, "R10 pin low", pin_level, 0);
      run(8, 700, cyc);
      chk(result == 20'd0, "R10 no count in port role", result, 0);
      cfg(2'b00, 2'b00, 1'b0);
      sig_in = 1'b1; repeat (3) @(negedge clk);
      chk(pin_level == 1'b0, "R10 pin masked in count role", pin_level, 1'b0);
      sig_in = 1'b0;

      // R8 saturation in narrow instance
      cfg(2'b00, 2'b01, 1'b0);
      run(80, 1600, cyc);
      chk(result == 20'd80, "R8 wide count", result, 80);
      chk(s_result == 6'd63, "R8 saturate", s_result, 63);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule